// File: doc/BRIEF.md
# Byte-Pair Pixel Reassembler

This block sits behind the depacketiser of a camera serial link that carries a 16-bit image as an 8-bit payload. It takes the payload bytes of each row, together with three single-cycle markers: frame start, frame end and row (long packet) start. It joins each pair of consecutive bytes into one 16-bit pixel, taking the first byte of the pair as the low byte. It tags every pixel with its row and column. It also checks the frame shape against a fixed geometry of `ROWS` rows of `2*COLS` bytes, which is 1024 rows of 2560 bytes by default.

The byte input is a valid/ready stream. The block accepts a byte on any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in that cycle, and no marker is asserted in that cycle. Markers are plain pulses with no handshake, and the source must not hold a byte waiting while it pulses a marker.

The pixel output is a registered valid/ready stream. Once `px_valid` rises, the pixel and its labels hold steady until `px_ready` is seen high. A colour mode labels the pixels of each row with a repeating chroma-before-luma component sequence. Two single-cycle error pulses report rows of the wrong length and frames with the wrong number of rows.

Top module: `pix_pair_join`

## Requirements
- R1: Within an open row, accepted bytes pair up in order. On the second byte of a pair, `px_data` becomes {second byte, first byte}, and `px_valid` is high from the next cycle.
- R2: `in_ready` equals (`px_valid` low or `px_ready` high) and no marker asserted. While `px_valid` is high and `px_ready` is low, every pixel output holds its value.
- R3: `px_row` is the 0-based count of accepted row starts in the current frame before this row. `px_col` counts pixels from 0 within the row.
- R4: When an open row is closed by a row start, a frame end or a frame start, `row_len_err` pulses for one cycle in the next cycle if the row did not carry exactly `2*COLS` bytes. Bytes past `2*COLS` and an unpaired last byte produce no pixel.
- R5: On a frame end inside a frame, `frame_cnt_err` pulses for one cycle in the next cycle if the frame did not hold exactly `ROWS` row starts. A frame start resets the row count.
- R6: With `uyvy_en` high, `px_tag` runs 0 (U), 1 (Y), 2 (V), 3 (Y) and restarts at 0 with each row.
- R7: With `uyvy_en` low at the cycle a pixel is formed, its `px_tag` is 0.
- R8: `frame_valid` is high from the cycle after a frame start until the cycle after a frame end. `line_valid` is high from the cycle after an accepted row start until the row closes. A row start outside a frame is ignored, and bytes accepted with no row open produce no pixel.
- R9: After reset `px_valid`, `line_valid`, `frame_valid` and both error pulses are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sof_i | input | 1 | Frame start pulse |
| eof_i | input | 1 | Frame end pulse |
| row_start_i | input | 1 | Row (long packet) start pulse |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| in_byte | input | 8 | Payload byte |
| uyvy_en | input | 1 | Component labelling mode |
| px_valid | output | 1 | Pixel valid |
| px_ready | input | 1 | Pixel consumer ready |
| px_data | output | 16 | Reassembled pixel |
| px_row | output | $clog2(ROWS+2) | Row index |
| px_col | output | $clog2(COLS+1) | Column index |
| px_tag | output | 2 | Component label |
| line_valid | output | 1 | A row is open |
| frame_valid | output | 1 | Inside a frame |
| row_len_err | output | 1 | Wrong row length pulse |
| frame_cnt_err | output | 1 | Wrong row count pulse |

## Verification
The bench targets these cases:
- A row ending on an odd byte: a design that kept the leftover byte would pair it into the next row, and every later pixel would be off by one byte.
- Rows that are too long and rows that are too short: a design that counted only up to the limit would miss the long row.
- Frames with too few and too many rows, and a frame start arriving in the middle of a row: without the close-on-restart rule the cut row would go unreported.
- Heavy output back-pressure combined with the colour mode: a design that loaded over a held pixel or advanced the tag while stalled would show changed data or a skipped component.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    COMP_U  = 2'd0,
    COMP_Y0 = 2'd1,
    COMP_V  = 2'd2,
    COMP_Y1 = 2'd3
  } comp_e;

  function automatic comp_e comp_next(comp_e c);
    case (c)
      COMP_U:  return COMP_Y0;
      COMP_Y0: return COMP_V;
      COMP_V:  return COMP_Y1;
      default: return COMP_U;
    endcase
  endfunction
endpackage

// File: rtl/pp_frame_ctl.sv
module pp_frame_ctl #(
  parameter int unsigned ROWS = 1024
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sof_i,
  input  logic                        eof_i,
  input  logic                        row_start_i,
  output logic                        frame_on,
  output logic                        row_open,
  output logic [$clog2(ROWS+2)-1:0]   row_idx,
  output logic                        row_begin,
  output logic                        row_close,
  output logic                        frame_err
);
  localparam int unsigned ROW_W = $clog2(ROWS + 2);
  localparam logic [ROW_W-1:0] ROW_SAT = ROW_W'(ROWS + 1);
  localparam logic [ROW_W-1:0] ROW_EXP = ROW_W'(ROWS);

  logic [ROW_W-1:0] rows_seen;

  // frame start wins over frame end, which wins over row start
  assign row_close = row_open & (sof_i | eof_i | row_start_i);
  assign row_begin = row_start_i & frame_on & ~sof_i & ~eof_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_on  <= 1'b0;
      row_open  <= 1'b0;
      rows_seen <= '0;
      row_idx   <= '0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      if (sof_i) begin
        frame_on  <= 1'b1;
        row_open  <= 1'b0;
        rows_seen <= '0;
      end else if (eof_i) begin
        if (frame_on) begin
          frame_err <= (rows_seen != ROW_EXP);
          frame_on  <= 1'b0;
          row_open  <= 1'b0;
        end
      end else if (row_begin) begin
        row_open <= 1'b1;
        row_idx  <= rows_seen;
        if (rows_seen != ROW_SAT) rows_seen <= rows_seen + ROW_W'(1);
      end
    end
  end

  // R8: a row can only be open inside a frame
  p_line_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
    row_open |-> frame_on);

  // R5: the count error only follows a frame end seen inside a frame
  p_ferr_after_eof_r5: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> $past(eof_i & frame_on & ~sof_i));
endmodule

// File: rtl/pp_len_chk.sv
module pp_len_chk #(
  parameter int unsigned COLS = 1280
) (
  input  logic clk,
  input  logic rst,
  input  logic row_open,
  input  logic row_begin,
  input  logic row_close,
  input  logic byte_fire,
  output logic keep,
  output logic row_err
);
  localparam int unsigned ROW_BYTES = 2 * COLS;
  localparam int unsigned BW = $clog2(ROW_BYTES + 2);
  localparam logic [BW-1:0] CNT_FULL = BW'(ROW_BYTES);
  localparam logic [BW-1:0] CNT_SAT  = BW'(ROW_BYTES + 1);

  logic [BW-1:0] cnt;

  assign keep = row_open & (cnt < CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      row_err <= 1'b0;
    end else begin
      row_err <= row_close & (cnt != CNT_FULL);
      if (row_begin) cnt <= '0;
      else if (byte_fire && row_open && cnt != CNT_SAT) cnt <= cnt + BW'(1);
    end
  end

  // R4: a length error pulse is always preceded by a row closing
  p_rerr_after_close_r4: assert property (@(posedge clk) disable iff (rst)
    row_err |-> $past(row_close));
endmodule

// File: rtl/pp_pair_out.sv
module pp_pair_out
  import pp_pkg::*;
#(
  parameter int unsigned COLS  = 1280,
  parameter int unsigned ROW_W = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       row_begin,
  input  logic                       take,
  input  logic [7:0]                 in_byte,
  input  logic                       uyvy_en,
  input  logic [ROW_W-1:0]           row_idx,
  input  logic                       px_ready,
  output logic                       px_valid,
  output logic [15:0]                px_data,
  output logic [ROW_W-1:0]           px_row,
  output logic [$clog2(COLS+1)-1:0]  px_col,
  output logic [1:0]                 px_tag
);
  localparam int unsigned CW = $clog2(COLS + 1);

  logic          phase;
  logic [7:0]    lo_byte;
  logic [CW-1:0] col_cnt;
  comp_e         tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      lo_byte  <= '0;
      col_cnt  <= '0;
      tag      <= COMP_U;
      px_valid <= 1'b0;
      px_data  <= '0;
      px_row   <= '0;
      px_col   <= '0;
      px_tag   <= '0;
    end else begin
      if (px_valid && px_ready) px_valid <= 1'b0;
      if (row_begin) begin
        phase   <= 1'b0;
        col_cnt <= '0;
        tag     <= COMP_U;
      end else if (take) begin
        if (!phase) begin
          lo_byte <= in_byte;
          phase   <= 1'b1;
        end else begin
          px_valid <= 1'b1;
          px_data  <= {in_byte, lo_byte};
          px_row   <= row_idx;
          px_col   <= col_cnt;
          px_tag   <= uyvy_en ? 2'(tag) : 2'(COMP_U);
          col_cnt  <= col_cnt + CW'(1);
          tag      <= comp_next(tag);
          phase    <= 1'b0;
        end
      end
    end
  end

  // R2: a stalled pixel is neither dropped nor overwritten
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_data) && $stable(px_col) && $stable(px_tag)));

  // R3: column labels stay inside the row width
  p_col_range_r3: assert property (@(posedge clk) disable iff (rst)
    px_valid |-> (px_col < CW'(COLS)));
endmodule

// File: rtl/pix_pair_join.sv
module pix_pair_join #(
  parameter int unsigned ROWS = 1024,
  parameter int unsigned COLS = 1280
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sof_i,
  input  logic                       eof_i,
  input  logic                       row_start_i,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [7:0]                 in_byte,
  input  logic                       uyvy_en,
  output logic                       px_valid,
  input  logic                       px_ready,
  output logic [15:0]                px_data,
  output logic [$clog2(ROWS+2)-1:0]  px_row,
  output logic [$clog2(COLS+1)-1:0]  px_col,
  output logic [1:0]                 px_tag,
  output logic                       line_valid,
  output logic                       frame_valid,
  output logic                       row_len_err,
  output logic                       frame_cnt_err
);
  localparam int unsigned ROW_W = $clog2(ROWS + 2);

  logic             row_open, frame_on, row_begin, row_close;
  logic             keep, fire;
  logic [ROW_W-1:0] row_idx;

  assign in_ready    = (~px_valid | px_ready) & ~(sof_i | eof_i | row_start_i);
  assign fire        = in_valid & in_ready;
  assign line_valid  = row_open;
  assign frame_valid = frame_on;

  pp_frame_ctl #(.ROWS(ROWS)) u_frame (
    .clk(clk), .rst(rst), .sof_i(sof_i), .eof_i(eof_i), .row_start_i(row_start_i),
    .frame_on(frame_on), .row_open(row_open), .row_idx(row_idx),
    .row_begin(row_begin), .row_close(row_close), .frame_err(frame_cnt_err)
  );

  pp_len_chk #(.COLS(COLS)) u_len (
    .clk(clk), .rst(rst), .row_open(row_open), .row_begin(row_begin),
    .row_close(row_close), .byte_fire(fire), .keep(keep), .row_err(row_len_err)
  );

  pp_pair_out #(.COLS(COLS), .ROW_W(ROW_W)) u_pair (
    .clk(clk), .rst(rst), .row_begin(row_begin), .take(fire & keep),
    .in_byte(in_byte), .uyvy_en(uyvy_en), .row_idx(row_idx), .px_ready(px_ready),
    .px_valid(px_valid), .px_data(px_data), .px_row(px_row), .px_col(px_col),
    .px_tag(px_tag)
  );

  // R2: no byte is taken while a marker is present or the output is blocked
  p_no_take_when_full_r2: assert property (@(posedge clk) disable iff (rst)
    (px_valid && !px_ready) |-> !in_ready);
endmodule

// File: tb/test_pix_pair_join.sv
module test_pix_pair_join;
  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int RB   = 2 * COLS;
  localparam int RW   = $clog2(ROWS + 2);
  localparam int CW   = $clog2(COLS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic sof = 0, eof = 0, rs = 0, in_valid = 0, uyvy_en = 0, px_ready = 1;
  logic [7:0] in_byte = '0;
  logic in_ready, px_valid, line_valid, frame_valid, row_len_err, frame_cnt_err;
  logic [15:0] px_data;
  logic [RW-1:0] px_row;
  logic [CW-1:0] px_col;
  logic [1:0] px_tag;

  pix_pair_join #(.ROWS(ROWS), .COLS(COLS)) i_pix_pair_join (
    .clk(clk), .rst(rst), .sof_i(sof), .eof_i(eof), .row_start_i(rs),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte), .uyvy_en(uyvy_en),
    .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data), .px_row(px_row),
    .px_col(px_col), .px_tag(px_tag), .line_valid(line_valid), .frame_valid(frame_valid),
    .row_len_err(row_len_err), .frame_cnt_err(frame_cnt_err)
  );

  int n_cmp = 0, n_bad = 0, cyc_n = 0;
  bit stall_mode = 0;
  bit done = 0;
  logic [7:0] bv = 8'h01;

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, got, exp, $time);
    end
  endtask

  // behavioural reference model, stepped at each rising edge
  int m_fon, m_lopen, m_rows, m_ridx, m_bcnt, m_phase, m_lo, m_col, m_tag;
  int m_valid, m_data, m_prow, m_pcol, m_ptag, m_pmode, m_rerr, m_ferr;

  always @(posedge clk) begin : model
    int mk, rdy, fire;
    cyc_n++;
    if (rst) begin
      m_fon = 0; m_lopen = 0; m_rows = 0; m_ridx = 0; m_bcnt = 0; m_phase = 0;
      m_lo = 0; m_col = 0; m_tag = 0; m_valid = 0; m_data = 0; m_prow = 0;
      m_pcol = 0; m_ptag = 0; m_pmode = 0; m_rerr = 0; m_ferr = 0;
    end else begin
      mk   = int'(sof | eof | rs);
      rdy  = ((m_valid == 0) || px_ready) && (mk == 0) ? 1 : 0;
      fire = (in_valid && rdy != 0) ? 1 : 0;
      m_rerr = 0;
      m_ferr = 0;
      if (m_valid != 0 && px_ready) m_valid = 0;
      if (m_lopen != 0 && mk != 0 && m_bcnt != RB) m_rerr = 1;
      if (sof) begin
        m_fon = 1; m_lopen = 0; m_rows = 0;
      end else if (eof) begin
        if (m_fon != 0) begin
          m_ferr = (m_rows != ROWS) ? 1 : 0;
          m_fon = 0; m_lopen = 0;
        end
      end else if (rs) begin
        if (m_fon != 0) begin
          m_lopen = 1; m_ridx = m_rows;
          if (m_rows < ROWS + 1) m_rows++;
          m_bcnt = 0; m_col = 0; m_tag = 0; m_phase = 0;
        end
      end else if (fire != 0 && m_lopen != 0) begin
        if (m_bcnt < RB) begin
          if (m_phase == 0) begin
            m_lo = in_byte; m_phase = 1;
          end else begin
            m_valid = 1;
            m_data  = int'(in_byte) * 256 + m_lo;
            m_prow  = m_ridx;
            m_pcol  = m_col;
            m_pmode = int'(uyvy_en);
            m_ptag  = uyvy_en ? m_tag : 0;
            m_col++;
            m_tag   = (m_tag + 1) % 4;
            m_phase = 0;
          end
        end
        if (m_bcnt < RB + 1) m_bcnt++;
      end
    end
  end

  // compare every output against the model at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 in_ready", int'(in_ready),
          ((m_valid == 0 || px_ready) && !(sof | eof | rs)) ? 1 : 0);
      chk("R1 px_valid", int'(px_valid), m_valid);
      if (m_valid != 0) begin
        chk("R1 px_data", int'(px_data), m_data);
        chk("R3 px_row", int'(px_row), m_prow);
        chk("R3 px_col", int'(px_col), m_pcol);
        chk(m_pmode != 0 ? "R6 px_tag" : "R7 px_tag", int'(px_tag), m_ptag);
      end
      chk("R8 line_valid", int'(line_valid), m_lopen);
      chk("R8 frame_valid", int'(frame_valid), m_fon);
      chk("R4 row_len_err", int'(row_len_err), m_rerr);
      chk("R5 frame_cnt_err", int'(frame_cnt_err), m_ferr);
    end
  end

  task automatic drive(input bit s, input bit e, input bit r, input bit v, input logic [7:0] d);
    @(posedge clk); #2;
    sof = s; eof = e; rs = r; in_valid = v; in_byte = d;
    px_ready = stall_mode ? ((cyc_n % 3) != 0) : 1'b1;
  endtask

  task automatic put();
    drive(0, 0, 0, 1, bv);
    bv = bv + 8'd7;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      @(posedge clk); #2;
      px_ready = stall_mode ? ((cyc_n % 3) != 0) : 1'b1;
    end
  endtask

  task automatic mark(input bit s, input bit e, input bit r);
    drive(s, e, r, 0, 8'h00);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 8'h00);
  endtask

  task automatic row(input int nbytes);
    mark(0, 0, 1);
    for (int i = 0; i < nbytes; i++) put();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    // R9: reset state
    chk("R9 px_valid", int'(px_valid), 0);
    chk("R9 in_ready", int'(in_ready), 1);
    chk("R9 frame_valid", int'(frame_valid), 0);
    chk("R9 line_valid", int'(line_valid), 0);
    chk("R9 errors", int'(row_len_err | frame_cnt_err), 0);

    // R8: row start outside a frame ignored, stray byte discarded
    mark(0, 0, 1);
    put();
    idle(2);

    // frame A: well formed, plain labels (R1, R3, R7)
    mark(1, 0, 0);
    put();                       // R8: byte before any row start
    for (int r = 0; r < ROWS; r++) row(RB);
    mark(0, 1, 0);
    idle(3);

    // frame B: colour labels under back-pressure (R2, R6)
    uyvy_en = 1; stall_mode = 1;
    mark(1, 0, 0);
    for (int r = 0; r < ROWS; r++) row(RB);
    mark(0, 1, 0);
    idle(4);

    // frame C: odd short row, long row, too few rows (R4, R5)
    uyvy_en = 0; stall_mode = 0;
    mark(1, 0, 0);
    row(RB - 1);
    row(RB + 2);
    mark(0, 1, 0);
    idle(3);

    // frame D: one row too many (R5), colour mode toggled mid-frame (R6, R7)
    mark(1, 0, 0);
    for (int r = 0; r < ROWS + 1; r++) begin
      uyvy_en = r[0];
      row(RB);
    end
    mark(0, 1, 0);
    idle(3);

    // frame E: restart cuts an open row (R4), then a clean frame
    uyvy_en = 1;
    mark(1, 0, 0);
    row(4);
    mark(1, 0, 0);
    for (int r = 0; r < ROWS; r++) row(RB);
    mark(0, 1, 0);
    idle(5);

    done = 1;
    summary();
    $finish;
  end
endmodule